// File: doc/BRIEF.md
# Bit-Doubled Return Channel Codec

This block carries a small set of status and command signals over a slow return path. Each value is sent twice. On the sending side it takes four return lines, a flow-control stop request (XOFF), a link-down flag and a remote-reset request. It packs them into a 16-bit word in which every logical bit appears as two identical adjacent bits. The encoder puts out one such word and then seven idle cycles, and repeats this without end. The steady sparse cadence helps the far-end receiver find and keep its lock.

On the receiving side the decoder checks every bit pair of an arriving word. A pair of 2'b11 means asserted and 2'b00 means deasserted. A pair of 2'b01 or 2'b10 marks the whole word as corrupt, and the decoder drops it. Decoded outputs change only when a clean word arrives. Otherwise they keep their last good values. A one-cycle strobe marks each accepted word. The serializer, clock-domain crossing and link state machines sit outside this block. The word port and its valid flag stand in for the physical channel.

Top module: `retc_codec`

## Requirements
- R1: Each transmitted word carries every logical bit as a pair of two equal bits: bit 2i+1 equals bit 2i for every pair i.
- R2: Pair layout of the word: pairs [1:0], [3:2], [5:4], [7:6] carry return lines 0 to 3; [9:8] carries XOFF; [11:10] carries link-down; [13:12] carries remote reset. The encoder always drives the reserved pair [15:14] as 2'b00.
- R3: After reset, `tx_vld_o` first goes high in the cycle after the first clock edge. It then stays low for exactly seven cycles between consecutive words. `tx_word_o` is all zero in every idle cycle.
- R4: The encoder samples its inputs only at the clock edge that launches a word. Input changes during idle cycles do not alter the word on the line and only appear in the next word.
- R5: An accepted word drives each decoded output high for pair 2'b11 and low for pair 2'b00. The outputs are registered, so they appear one cycle after the word.
- R6: If any pair, including the reserved pair, holds 2'b01 or 2'b10, the whole word is discarded. All decoded outputs keep their previous values and no strobe is issued.
- R7: A cycle with `rx_vld_i` low is an idle cycle. The word contents are then ignored, the outputs hold and no strobe is issued.
- R8: `rx_good_o` is high for exactly one cycle for each accepted word, in the cycle after that word. Back-to-back good words give back-to-back strobes.
- R9: During reset, `tx_vld_o`, `tx_word_o`, all decoded outputs and `rx_good_o` are zero.
- R10: The value of a matching reserved pair (2'b00 or 2'b11) does not affect any decoded output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ret_line_i | input | 4 | Return lines to send |
| xoff_i | input | 1 | Flow-control stop request to send |
| link_down_i | input | 1 | Link-down indication to send |
| rem_reset_i | input | 1 | Remote reset request to send |
| tx_word_o | output | 16 | Encoded word toward the serializer |
| tx_vld_o | output | 1 | High in a word cycle, low in an idle cycle |
| rx_word_i | input | 16 | Received word from the deserializer |
| rx_vld_i | input | 1 | High when `rx_word_i` holds a word |
| ret_line_o | output | 4 | Decoded return lines |
| xoff_o | output | 1 | Decoded XOFF |
| link_down_o | output | 1 | Decoded link-down |
| rem_reset_o | output | 1 | Decoded remote reset |
| rx_good_o | output | 1 | One-cycle strobe per accepted word |

## Verification
The assertions check the following on every cycle:
- pair equality in every sent word;
- the zero reserved pair and the all-zero idle word;
- the exact seven-cycle gap, tracked with a counter;
- that outputs stay put and no strobe appears after a corrupt or idle input;
- that each strobe's outputs match the word from the cycle before.

Some behaviours only the bench scenarios can show. The encoder sampling point (R4) is shown by moving the inputs at chosen idle cycles and observing which word carries them. The end-to-end loopback shows that a sent word decodes to the values that were put in. The scoreboard covers corruption placed in a single payload pair and in the reserved pair only.

// File: rtl/retc_pkg.sv
package retc_pkg;
  // command fields that follow the return lines, in word order
  localparam int unsigned CMD_FIELDS = 4;
  localparam int unsigned OFS_XOFF   = 0;
  localparam int unsigned OFS_DOWN   = 1;
  localparam int unsigned OFS_RRST   = 2;
  localparam int unsigned OFS_RSVD   = 3;

  function automatic logic [1:0] dup_bit(input logic b);
    return {b, b};
  endfunction
endpackage

// File: rtl/retc_pair_chk.sv
module retc_pair_chk (
  input  logic [1:0] pair_i,
  output logic       ok_o
);
  assign ok_o = (pair_i[1] == pair_i[0]);
endmodule

// File: rtl/retc_encoder.sv
module retc_encoder
  import retc_pkg::*;
#(
  parameter int unsigned N_LINES     = 4,
  parameter int unsigned IDLE_CYCLES = 7
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic [N_LINES-1:0]                   ret_line_i,
  input  logic                                 xoff_i,
  input  logic                                 link_down_i,
  input  logic                                 rem_reset_i,
  output logic [2*(N_LINES+CMD_FIELDS)-1:0]    tx_word_o,
  output logic                                 tx_vld_o
);
  localparam int unsigned NBITS  = N_LINES + CMD_FIELDS;
  localparam int unsigned WORD_W = 2 * NBITS;
  localparam int unsigned PERIOD = IDLE_CYCLES + 1;
  localparam int unsigned CNT_W  = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam int unsigned IDLE_W = $clog2(IDLE_CYCLES + 2);

  logic [NBITS-1:0]  bits_d;
  logic [WORD_W-1:0] word_d;
  logic [CNT_W-1:0]  cnt_q;
  logic              launch;

  assign bits_d = {1'b0, rem_reset_i, link_down_i, xoff_i, ret_line_i};

  for (genvar i = 0; i < NBITS; i++) begin : g_dup
    assign word_d[2*i +: 2] = dup_bit(bits_d[i]);
  end

  assign launch = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      tx_word_o <= '0;
      tx_vld_o  <= 1'b0;
    end else begin
      tx_vld_o  <= launch;
      tx_word_o <= launch ? word_d : '0;
      cnt_q     <= (cnt_q == CNT_W'(PERIOD - 1)) ? '0 : cnt_q + 1'b1;
    end
  end

  // ---- checks on the sent stream ----
  logic [NBITS-1:0]  tx_hi, tx_lo;
  logic [IDLE_W-1:0] idle_q;
  logic              seen_q;

  for (genvar i = 0; i < NBITS; i++) begin : g_split
    assign tx_hi[i] = tx_word_o[2*i+1];
    assign tx_lo[i] = tx_word_o[2*i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_q <= '0;
      seen_q <= 1'b0;
    end else if (tx_vld_o) begin
      idle_q <= '0;
      seen_q <= 1'b1;
    end else if (idle_q != IDLE_W'(IDLE_CYCLES + 1)) begin
      idle_q <= idle_q + 1'b1;
    end
  end

  assert_pairs_equal_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_vld_o |-> (tx_hi == tx_lo));

  assert_rsvd_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_vld_o |-> (tx_word_o[WORD_W-1 -: 2] == 2'b00));

  assert_idle_word_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_vld_o |-> (tx_word_o == '0));

  assert_gap_exact_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_vld_o && seen_q) |-> (idle_q == IDLE_W'(IDLE_CYCLES)));

  assert_gap_min_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_vld_o && seen_q) |-> (idle_q < IDLE_W'(IDLE_CYCLES + 1)));
endmodule

// File: rtl/retc_decoder.sv
module retc_decoder
  import retc_pkg::*;
#(
  parameter int unsigned N_LINES = 4
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [2*(N_LINES+CMD_FIELDS)-1:0] rx_word_i,
  input  logic                              rx_vld_i,
  output logic [N_LINES-1:0]                ret_line_o,
  output logic                              xoff_o,
  output logic                              link_down_o,
  output logic                              rem_reset_o,
  output logic                              rx_good_o
);
  localparam int unsigned NBITS  = N_LINES + CMD_FIELDS;
  localparam int unsigned B_XOFF = N_LINES + OFS_XOFF;
  localparam int unsigned B_DOWN = N_LINES + OFS_DOWN;
  localparam int unsigned B_RRST = N_LINES + OFS_RRST;

  logic [NBITS-1:0]   pair_ok;
  logic [N_LINES-1:0] line_val;
  logic               all_ok, accept;

  for (genvar i = 0; i < NBITS; i++) begin : g_chk
    retc_pair_chk u_chk (
      .pair_i (rx_word_i[2*i +: 2]),
      .ok_o   (pair_ok[i])
    );
  end

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    assign line_val[i] = rx_word_i[2*i];
  end

  assign all_ok = &pair_ok;
  assign accept = rx_vld_i && all_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ret_line_o  <= '0;
      xoff_o      <= 1'b0;
      link_down_o <= 1'b0;
      rem_reset_o <= 1'b0;
      rx_good_o   <= 1'b0;
    end else begin
      rx_good_o <= accept;
      if (accept) begin
        ret_line_o  <= line_val;
        xoff_o      <= rx_word_i[2*B_XOFF];
        link_down_o <= rx_word_i[2*B_DOWN];
        rem_reset_o <= rx_word_i[2*B_RRST];
      end
    end
  end

  // ---- checks on the decoded side ----
  logic [NBITS-2:0] rx_lo;
  for (genvar i = 0; i < NBITS - 1; i++) begin : g_lo
    assign rx_lo[i] = rx_word_i[2*i];
  end

  assert_discard_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_vld_i && !all_ok) |=> (!rx_good_o && $stable(ret_line_o) && $stable(xoff_o)
                               && $stable(link_down_o) && $stable(rem_reset_o)));

  assert_idle_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_vld_i |=> (!rx_good_o && $stable(ret_line_o) && $stable(xoff_o)
                   && $stable(link_down_o) && $stable(rem_reset_o)));

  assert_strobe_source_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_good_o |-> $past(rx_vld_i));

  assert_values_match_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_good_o |-> ({rem_reset_o, link_down_o, xoff_o, ret_line_o} == $past(rx_lo)));
endmodule

// File: rtl/retc_codec.sv
module retc_codec
  import retc_pkg::*;
#(
  parameter int unsigned N_LINES     = 4,
  parameter int unsigned IDLE_CYCLES = 7
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [N_LINES-1:0]                ret_line_i,
  input  logic                              xoff_i,
  input  logic                              link_down_i,
  input  logic                              rem_reset_i,
  output logic [2*(N_LINES+CMD_FIELDS)-1:0] tx_word_o,
  output logic                              tx_vld_o,
  input  logic [2*(N_LINES+CMD_FIELDS)-1:0] rx_word_i,
  input  logic                              rx_vld_i,
  output logic [N_LINES-1:0]                ret_line_o,
  output logic                              xoff_o,
  output logic                              link_down_o,
  output logic                              rem_reset_o,
  output logic                              rx_good_o
);
  retc_encoder #(.N_LINES(N_LINES), .IDLE_CYCLES(IDLE_CYCLES)) u_enc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ret_line_i  (ret_line_i),
    .xoff_i      (xoff_i),
    .link_down_i (link_down_i),
    .rem_reset_i (rem_reset_i),
    .tx_word_o   (tx_word_o),
    .tx_vld_o    (tx_vld_o)
  );

  retc_decoder #(.N_LINES(N_LINES)) u_dec (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rx_word_i   (rx_word_i),
    .rx_vld_i    (rx_vld_i),
    .ret_line_o  (ret_line_o),
    .xoff_o      (xoff_o),
    .link_down_o (link_down_o),
    .rem_reset_o (rem_reset_o),
    .rx_good_o   (rx_good_o)
  );
endmodule

// File: tb/retc_codec_test.sv
module retc_codec_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  lines_in = '0;
  logic        xoff_in = 1'b0, down_in = 1'b0, rrst_in = 1'b0;
  logic [15:0] tx_word;
  logic        tx_vld;
  logic [15:0] drv_word = '0;
  logic        drv_vld = 1'b0;
  logic        loop_en = 1'b0;
  logic [15:0] rx_word;
  logic        rx_vld;
  logic [3:0]  lines_out;
  logic        xoff_out, down_out, rrst_out, good_out;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  assign rx_word = loop_en ? tx_word : drv_word;
  assign rx_vld  = loop_en ? tx_vld  : drv_vld;

  retc_codec uut (
    .clk_i(clk), .rst_ni(rst_n),
    .ret_line_i(lines_in), .xoff_i(xoff_in), .link_down_i(down_in), .rem_reset_i(rrst_in),
    .tx_word_o(tx_word), .tx_vld_o(tx_vld),
    .rx_word_i(rx_word), .rx_vld_i(rx_vld),
    .ret_line_o(lines_out), .xoff_o(xoff_out), .link_down_o(down_out),
    .rem_reset_o(rrst_out), .rx_good_o(good_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected word per R1/R2: pair = 11 for set, 00 for clear, reserved 00
  function automatic logic [15:0] enc_exp(input logic [7:0] v);
    logic [15:0] w = '0;
    for (int i = 0; i < 7; i++) if (v[i]) w[2*i +: 2] = 2'b11;
    return w;
  endfunction

  typedef struct {
    logic [7:0] vals;  // {good, rrst, down, xoff, lines}
    string      req;
  } exp_t;
  exp_t        sb_q[$];
  logic [6:0]  model = '0;

  task automatic send(input logic [15:0] w, input logic v, input string req);
    exp_t e;
    logic ok = 1'b1;
    @(negedge clk);
    drv_word = w;
    drv_vld  = v;
    for (int i = 0; i < 8; i++) if (w[2*i] != w[2*i+1]) ok = 1'b0;
    if (v && ok) for (int i = 0; i < 7; i++) model[i] = w[2*i];
    e.vals = {v && ok, model};
    e.req  = req;
    sb_q.push_back(e);
  endtask

  // monitor: compare decoder outputs after each edge against the queue
  always begin
    exp_t e;
    @(posedge clk);
    #2;
    if (sb_q.size() > 0) begin
      e = sb_q.pop_front();
      chk(e.req, {24'h0, good_out, rrst_out, down_out, xoff_out, lines_out}, {24'h0, e.vals});
    end
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] a, b, c, cur;
    a = 8'b0010_0110;  // down=1, lines=0110
    b = 8'b0101_1001;  // rrst=1, xoff=1, lines=1001
    c = 8'b0001_0011;  // xoff=1, lines=0011
    {rrst_in, down_in, xoff_in, lines_in} = a[6:0];
    loop_en = 1'b1;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 tx_vld", {31'h0, tx_vld}, 32'h0);
    chk("R9 tx_word", {16'h0, tx_word}, 32'h0);
    chk("R9 outputs", {27'h0, good_out, rrst_out, down_out, xoff_out, lines_out[0]}, 32'h0);
    chk("R9 lines", {28'h0, lines_out}, 32'h0);
    rst_n = 1'b1;

    // encoder cadence, sampling and loopback decode
    cur = a;
    for (int n = 0; n < 24; n++) begin
      @(negedge clk);
      if (n % 8 == 0) begin
        chk("R3 word cycle", {31'h0, tx_vld}, 32'h1);
        chk("R1 R2 word", {16'h0, tx_word}, {16'h0, enc_exp((n == 0) ? a : (n == 8) ? b : c)});
      end else begin
        chk("R3 idle cycle", {31'h0, tx_vld}, 32'h0);
        chk("R3 R4 idle word", {16'h0, tx_word}, 32'h0);
      end
      if (n % 8 == 1) begin
        cur = (n == 1) ? a : (n == 9) ? b : c;
        chk("R5 loopback", {24'h0, good_out, rrst_out, down_out, xoff_out, lines_out},
            {24'h0, 1'b1, cur[6:0]});
      end else if (n > 0) begin
        chk("R8 no strobe", {31'h0, good_out}, 32'h0);
      end
      // R4: inputs moved during idle only show in the next word
      if (n == 3) {rrst_in, down_in, xoff_in, lines_in} = 7'h7F;
      if (n == 5) {rrst_in, down_in, xoff_in, lines_in} = b[6:0];
      if (n == 9) {rrst_in, down_in, xoff_in, lines_in} = c[6:0];
    end

    // decoder scoreboard, driven directly
    loop_en = 1'b0;
    model = c[6:0];
    send(16'h0000, 1'b1, "R5 all clear");
    send(16'h03CC, 1'b1, "R5 lines 1010 xoff");
    send(16'hFFFF, 1'b0, "R7 idle ignored");
    send(16'h04FF, 1'b1, "R6 bad link-down pair");
    send(16'h4000, 1'b1, "R6 bad reserved pair");
    send(16'hF000, 1'b1, "R10 reserved 11 accepted");
    send(16'h0C03, 1'b1, "R8 back to back 1");
    send(16'h0C03, 1'b1, "R8 back to back 2");
    send(16'h0002, 1'b1, "R6 pair 10");
    send(16'h0300, 1'b0, "R7 idle");
    send(16'h3FFF, 1'b1, "R5 all set");
    send(16'h0000, 1'b0, "R7 final idle");
    wait (sb_q.size() == 0);
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule